// File: doc/BRIEF.md
# Codec Host Bus Slave

This block sits between a host's 8-bit bus and the core of an audio codec. The host reaches four directly addressed registers through programmed I/O. A two-bit address picks the register, and an active-low chip select qualifies the cycle. The read and write strobes are separate and both active low. Playback samples arrive by DMA. A write strobe seen while the active-low playback acknowledge is low loads a one-byte sample register. The chip select plays no part in that transfer.

All bus inputs pass through a two-stage synchronizer. A write commits on the rising edge of the synchronized write strobe, using the address and data that were synchronized alongside it. The host must therefore hold the address, data and selects steady for at least three clock cycles after the strobe rises.

The block drives the enable and direction pins of an external transceiver. It also raises an active-high interrupt from a sticky event flag, gated by an enable bit. When a DMA cycle and a selected I/O cycle occur together, the DMA transfer wins and a collision flag records the lost I/O cycle.

Top module: `codec_hostbus`

## Requirements
- R1: Address 0 is a control register, 8 bits, readable and writable; bit 0 enables the interrupt. Address 1 is an 8-bit scratch register, readable and writable. Address 2 reads as {6'b0, collision, event pending}. Address 3 reads the playback sample register.
- R2: While cs_n is high, an I/O write changes no register. An I/O read with cs_n high leaves data_oe low, data_out zero and xcvr_en_n high.
- R3: A DMA write loads data_in into the playback sample register whatever the level of cs_n. A DMA write is a wr_n rising edge with pb_ack_n low. The sample shows on play_sample and on reads of address 3. I/O writes to address 3 are ignored.
- R4: A write takes effect on the rising edge of wr_n. The new value is visible no later than 3 clock cycles after that edge.
- R5: xcvr_en_n is low only while a strobe is active in a cycle the block takes part in. Those cycles are an I/O cycle with cs_n low and pb_ack_n high, or a write with pb_ack_n low. Otherwise xcvr_en_n is high.
- R6: xcvr_dir is high except while the block drives read data. During a selected I/O read, data_oe is 1, xcvr_dir is 0 and data_out carries the addressed register.
- R7: A one-cycle event_in pulse sets status bit 0. Writing 1 to that bit clears it, and writing 0 leaves it. If a set and a clear land in the same cycle, the set wins.
- R8: irq equals status bit 0 AND control bit 0.
- R9: If cs_n and pb_ack_n are both low when a strobe rises, the I/O access is dropped. A write still loads the sample, and status bit 1 is set. Writing 1 to status bit 1 clears it.
- R10: After reset every register reads 0, irq is 0, xcvr_en_n is 1, xcvr_dir is 1 and data_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select for programmed I/O, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| pb_ack_n | input | 1 | Playback DMA acknowledge, active low |
| addr | input | 2 | Register select |
| data_in | input | 8 | Write data from host |
| event_in | input | 1 | Single-cycle internal service event |
| data_out | output | 8 | Read data toward host |
| data_oe | output | 1 | High while data_out is driven |
| xcvr_en_n | output | 1 | Transceiver enable, active low |
| xcvr_dir | output | 1 | Transceiver direction, 1 toward codec |
| irq | output | 1 | Interrupt request, active high |
| play_sample | output | 8 | Last DMA playback sample |

## Verification
The hardest case to reach from the ports is an event pulse that lands in the same clock cycle as a write-one-to-clear of the pending bit. That cycle sits behind the synchronizer and the edge detector. The bench counts the register stages from the moment it raises wr_n and pulses event_in exactly in the commit cycle, then expects the bit to stay set. The collision path is reached by holding cs_n and pb_ack_n low together through a write and then through a read. The bench confirms that the I/O side was dropped, the sample was still taken and the flag was raised.

// File: rtl/chb_pkg.sv
// Shared constants and register selector type for the codec host bus slave.
// Assumes an 8-bit data path and four directly addressed registers.
package chb_pkg;
    localparam int DW = 8;
    localparam int AW = 2;

    typedef enum logic [AW-1:0] {
        SEL_CTRL    = 2'd0,
        SEL_SCRATCH = 2'd1,
        SEL_STATUS  = 2'd2,
        SEL_SAMPLE  = 2'd3
    } reg_sel_e;

    localparam int CTRL_IRQEN_BIT = 0;
    localparam int STAT_PEND_BIT  = 0;
    localparam int STAT_COLL_BIT  = 1;
endpackage

// File: rtl/chb_sync.sv
// Multi-stage synchronizer for a bus of asynchronous host inputs.
// Assumes the host holds the bundled signals steady long enough that all
// bits settle together; each stage resets to RST_VAL.
module chb_sync #(
    parameter int          W       = 8,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Shift the bus one stage deeper each clock.
            always_ff @(posedge clk) begin
                if (!rst_n)      stage_q[g] <= RST_VAL;
                else if (g == 0) stage_q[g] <= d;
                else             stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/chb_cycle_decode.sv
// Classifies synchronized bus activity into I/O writes, DMA playback writes,
// collisions and read drive; also produces transceiver controls.
// Assumes all inputs are already synchronized to clk.
module chb_cycle_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_s_n,
    input  logic wr_s_n,
    input  logic cs_s_n,
    input  logic dak_s_n,
    output logic io_wr_commit,
    output logic dma_commit,
    output logic collision_set,
    output logic rd_drive,
    output logic xcvr_en_n,
    output logic xcvr_dir
);
    logic rd_prev_n, wr_prev_n;
    logic rd_rise, wr_rise;
    logic io_sel;

    // Remember last strobe levels for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_prev_n <= 1'b1;
            wr_prev_n <= 1'b1;
        end else begin
            rd_prev_n <= rd_s_n;
            wr_prev_n <= wr_s_n;
        end
    end

    // Derive commit events and transceiver controls.
    always_comb begin
        rd_rise       = rd_s_n & ~rd_prev_n;
        wr_rise       = wr_s_n & ~wr_prev_n;
        io_sel        = ~cs_s_n & dak_s_n;
        io_wr_commit  = wr_rise & io_sel;
        dma_commit    = wr_rise & ~dak_s_n;
        collision_set = (rd_rise | wr_rise) & ~cs_s_n & ~dak_s_n;
        rd_drive      = ~rd_s_n & io_sel;
        xcvr_en_n     = ~((~wr_s_n & ~dak_s_n) | ((~rd_s_n | ~wr_s_n) & io_sel));
        xcvr_dir      = ~rd_drive;
    end

    assert_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !xcvr_dir |-> !xcvr_en_n);
    assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr_commit && dma_commit));
    assert_nocs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s_n |-> (!rd_drive && !io_wr_commit));
endmodule

// File: rtl/chb_regfile.sv
// Holds the control, scratch, status and playback sample registers, the
// sticky event and collision flags, and the interrupt output.
// Assumes single-cycle commit pulses from the cycle decoder.
module chb_regfile
    import chb_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          io_wr,
    input  logic          dma_wr,
    input  logic          coll_set,
    input  logic          event_in,
    output logic [DW-1:0] rdata,
    output logic          irq,
    output logic [DW-1:0] sample
);
    logic [DW-1:0] ctrl_q, scratch_q;
    logic          pend_q, coll_q;
    logic          stat_wr;

    assign stat_wr = io_wr && (reg_sel_e'(addr) == SEL_STATUS);

    // Update programmed registers on committed I/O writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            scratch_q <= '0;
        end else if (io_wr) begin
            if (reg_sel_e'(addr) == SEL_CTRL)    ctrl_q    <= wdata;
            if (reg_sel_e'(addr) == SEL_SCRATCH) scratch_q <= wdata;
        end
    end

    // Sticky flags: write-one-to-clear, new sets take precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            coll_q <= 1'b0;
        end else begin
            pend_q <= (pend_q & ~(stat_wr & wdata[STAT_PEND_BIT])) | event_in;
            coll_q <= (coll_q & ~(stat_wr & wdata[STAT_COLL_BIT])) | coll_set;
        end
    end

    // Capture playback samples from DMA writes.
    always_ff @(posedge clk) begin
        if (!rst_n)      sample <= '0;
        else if (dma_wr) sample <= wdata;
    end

    // Select read data by address.
    always_comb begin
        rdata = '0;
        unique case (reg_sel_e'(addr))
            SEL_CTRL:    rdata = ctrl_q;
            SEL_SCRATCH: rdata = scratch_q;
            SEL_STATUS: begin
                rdata[STAT_PEND_BIT] = pend_q;
                rdata[STAT_COLL_BIT] = coll_q;
            end
            SEL_SAMPLE:  rdata = sample;
            default:     rdata = '0;
        endcase
    end

    assign irq = pend_q & ctrl_q[CTRL_IRQEN_BIT];

    assert_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        event_in |=> pend_q);
    assert_coll_R9: assert property (@(posedge clk) disable iff (!rst_n)
        coll_set |=> coll_q);
    assert_dma_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dma_wr |=> (sample == $past(wdata)));
    assert_ro_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_wr |=> $stable(sample));
endmodule

// File: rtl/codec_hostbus.sv
// Host bus slave of an audio codec: synchronizes the host bus, decodes
// programmed I/O and playback DMA cycles, holds R0-R3 and drives the
// transceiver and interrupt. Assumes the host holds address, data and
// selects stable for 3 clocks after a strobe rises.
module codec_hostbus
    import chb_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          pb_ack_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data_in,
    input  logic          event_in,
    output logic [DW-1:0] data_out,
    output logic          data_oe,
    output logic          xcvr_en_n,
    output logic          xcvr_dir,
    output logic          irq,
    output logic [DW-1:0] play_sample
);
    localparam int BUS_W = 4 + AW + DW;
    localparam logic [BUS_W-1:0] BUS_RST = {4'hF, {(AW+DW){1'b0}}};

    logic [BUS_W-1:0] bus_s;
    logic             rd_s_n, wr_s_n, cs_s_n, dak_s_n;
    logic [AW-1:0]    addr_s;
    logic [DW-1:0]    data_s, rdata;
    logic             io_wr_commit, dma_commit, collision_set, rd_drive;

    chb_sync #(.W(BUS_W), .STAGES(2), .RST_VAL(BUS_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({rd_n, wr_n, cs_n, pb_ack_n, addr, data_in}),
        .q     (bus_s)
    );

    assign {rd_s_n, wr_s_n, cs_s_n, dak_s_n, addr_s, data_s} = bus_s;

    chb_cycle_decode u_dec (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_s_n        (rd_s_n),
        .wr_s_n        (wr_s_n),
        .cs_s_n        (cs_s_n),
        .dak_s_n       (dak_s_n),
        .io_wr_commit  (io_wr_commit),
        .dma_commit    (dma_commit),
        .collision_set (collision_set),
        .rd_drive      (rd_drive),
        .xcvr_en_n     (xcvr_en_n),
        .xcvr_dir      (xcvr_dir)
    );

    chb_regfile u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr_s),
        .wdata    (data_s),
        .io_wr    (io_wr_commit),
        .dma_wr   (dma_commit),
        .coll_set (collision_set),
        .event_in (event_in),
        .rdata    (rdata),
        .irq      (irq),
        .sample   (play_sample)
    );

    // Drive read data only during a selected read.
    always_comb begin
        data_oe  = rd_drive;
        data_out = rd_drive ? rdata : '0;
    end

    assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe |-> (data_out == '0 && xcvr_dir));
endmodule

// File: tb/codec_hostbus_test.sv
`timescale 1ns/1ps
module codec_hostbus_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, pb_ack_n = 1'b1;
    logic [1:0] addr = '0;
    logic [7:0] data_in = '0;
    logic       event_in = 1'b0;
    logic [7:0] data_out, play_sample;
    logic       data_oe, xcvr_en_n, xcvr_dir, irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [7:0] m_ctrl = 0, m_scr = 0, m_samp = 0;
    logic       m_pend = 0, m_coll = 0;

    always #2.5 clk = ~clk;

    codec_hostbus uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .pb_ack_n(pb_ack_n), .addr(addr), .data_in(data_in), .event_in(event_in),
        .data_out(data_out), .data_oe(data_oe), .xcvr_en_n(xcvr_en_n),
        .xcvr_dir(xcvr_dir), .irq(irq), .play_sample(play_sample)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_rd(input logic [1:0] a);
        case (a)
            2'd0: return m_ctrl;
            2'd1: return m_scr;
            2'd2: return {6'b0, m_coll, m_pend};
            default: return m_samp;
        endcase
    endfunction

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Generic write strobe; returns with strobe released and selects idle.
    task automatic bus_write(input logic [1:0] a, input logic [7:0] d,
                             input logic c_n, input logic k_n, input string req);
        @(negedge clk);
        addr = a; data_in = d; cs_n = c_n; pb_ack_n = k_n; wr_n = 1'b0;
        wait_n(4);
        check(xcvr_en_n == ((!c_n && k_n) || !k_n ? 1'b0 : 1'b1), "R5", xcvr_en_n,
              ((!c_n && k_n) || !k_n) ? 0 : 1);
        check(xcvr_dir == 1'b1, "R6", xcvr_dir, 1);
        wr_n = 1'b1;
        wait_n(4);
        cs_n = 1'b1; pb_ack_n = 1'b1;
        wait_n(3);
    endtask

    task automatic io_write(input logic [1:0] a, input logic [7:0] d);
        bus_write(a, d, 1'b0, 1'b1, "R4");
        if (a == 2'd0) m_ctrl = d;
        if (a == 2'd1) m_scr = d;
        if (a == 2'd2) begin
            if (d[0]) m_pend = 1'b0;
            if (d[1]) m_coll = 1'b0;
        end
    endtask

    task automatic io_read(input logic [1:0] a, input string req);
        logic [7:0] e;
        @(negedge clk);
        addr = a; cs_n = 1'b0; rd_n = 1'b0;
        wait_n(4);
        e = model_rd(a);
        check(data_oe == 1'b1 && data_out == e, req, data_out, e);
        check(xcvr_dir == 1'b0 && xcvr_en_n == 1'b0, "R6", {xcvr_dir, xcvr_en_n}, 0);
        rd_n = 1'b1;
        wait_n(4);
        cs_n = 1'b1;
        wait_n(3);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        wait_n(4);
        rst_n = 1'b1;
        wait_n(2);

        // R10: reset state
        check(irq == 0 && xcvr_en_n == 1 && xcvr_dir == 1 && data_oe == 0,
              "R10", {irq, xcvr_en_n, xcvr_dir, data_oe}, 4'b0110);
        check(play_sample == 0, "R10", play_sample, 0);
        for (int a = 0; a < 4; a++) io_read(a[1:0], "R10");

        // R1/R4: exhaustive value sweep on control and scratch
        for (int a = 0; a < 2; a++)
            for (int v = 0; v < 256; v++) begin
                io_write(a[1:0], v[7:0]);
                io_read(a[1:0], "R1");
            end
        io_write(2'd0, 8'h00);

        // R4: value visible within 3 cycles of the wr_n rising edge
        @(negedge clk);
        addr = 2'd1; data_in = 8'hC3; cs_n = 1'b0; wr_n = 1'b0;
        wait_n(3);
        wr_n = 1'b1;
        wait_n(3);
        cs_n = 1'b1; wait_n(3);
        m_scr = 8'hC3;
        io_read(2'd1, "R4");

        // R2: deselected writes and reads are ignored
        for (int a = 0; a < 4; a++) begin
            bus_write(a[1:0], 8'h5A ^ a[7:0], 1'b1, 1'b1, "R2");
            io_read(a[1:0], "R2");
        end
        @(negedge clk);
        addr = 2'd1; cs_n = 1'b1; rd_n = 1'b0;
        wait_n(4);
        check(data_oe == 0 && data_out == 0 && xcvr_en_n == 1, "R2",
              {data_oe, data_out, xcvr_en_n}, 10'h001);
        rd_n = 1'b1; wait_n(3);

        // R3: DMA sweep with cs_n high, exhaustive data
        for (int v = 0; v < 256; v++) begin
            bus_write(v[1:0], v[7:0], 1'b1, 1'b0, "R3");
            m_samp = v[7:0];
            check(play_sample == m_samp, "R3", play_sample, m_samp);
        end
        io_read(2'd3, "R3");
        check(model_rd(2'd1) == m_scr, "R3", m_scr, m_scr);
        io_read(2'd1, "R3");
        // R3: I/O write to sample register ignored
        io_write(2'd3, 8'h11);
        io_read(2'd3, "R3");
        check(play_sample == m_samp, "R3", play_sample, m_samp);

        // R7/R8: event, enable, clears
        check(irq == 0, "R8", irq, 0);
        @(negedge clk); event_in = 1'b1; @(negedge clk); event_in = 1'b0;
        m_pend = 1'b1;
        wait_n(1);
        check(irq == 0, "R8", irq, 0);
        io_read(2'd2, "R7");
        io_write(2'd0, 8'h01);
        check(irq == 1, "R8", irq, 1);
        io_write(2'd2, 8'h00);
        io_read(2'd2, "R7");
        check(irq == 1, "R8", irq, 1);
        io_write(2'd2, 8'h01);
        io_read(2'd2, "R7");
        check(irq == 0, "R8", irq, 0);

        // R7: set and clear in the same cycle, set wins
        @(negedge clk); event_in = 1'b1; @(negedge clk); event_in = 1'b0;
        @(negedge clk);
        addr = 2'd2; data_in = 8'h01; cs_n = 1'b0; wr_n = 1'b0;
        wait_n(4);
        wr_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        event_in = 1'b1;
        @(negedge clk);
        event_in = 1'b0;
        wait_n(3);
        cs_n = 1'b1; wait_n(3);
        m_pend = 1'b1;
        io_read(2'd2, "R7");
        check(irq == 1, "R8", irq, 1);
        io_write(2'd2, 8'h01);
        io_write(2'd0, 8'h00);

        // R9: write collision drops I/O, still samples, flags
        bus_write(2'd1, 8'hA5, 1'b0, 1'b0, "R9");
        m_samp = 8'hA5; m_coll = 1'b1;
        check(play_sample == 8'hA5, "R9", play_sample, 8'hA5);
        io_read(2'd1, "R9");
        io_read(2'd2, "R9");
        io_write(2'd2, 8'h02);
        io_read(2'd2, "R9");
        // R9: read collision is not driven and sets the flag
        @(negedge clk);
        addr = 2'd1; cs_n = 1'b0; pb_ack_n = 1'b0; rd_n = 1'b0;
        wait_n(4);
        check(data_oe == 0 && xcvr_dir == 1 && xcvr_en_n == 1, "R9",
              {data_oe, xcvr_dir, xcvr_en_n}, 3'b011);
        rd_n = 1'b1; wait_n(4);
        cs_n = 1'b1; pb_ack_n = 1'b1; wait_n(3);
        m_coll = 1'b1;
        io_read(2'd2, "R9");
        check(xcvr_en_n == 1 && xcvr_dir == 1, "R5", {xcvr_en_n, xcvr_dir}, 2'b11);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule